// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block generates the datapath control vector of a multicycle processor from a small built-in control store instead of hardwired next-state logic. A 4-bit micro-program counter addresses a constant table. Each word in that table carries 16 datapath control bits and a 2-bit address-control field. The field tells an address-select stage how to pick the next micro-address. It can go back to zero, look up either of two opcode-indexed dispatch tables, or increment.

Each instruction begins with a fetch word and then a decode word. The decode word branches on the 6-bit opcode to the first word of an instruction-class routine. Memory-reference routines branch a second time on the opcode to split loads from stores. Every routine ends by returning to micro-address 0. An opcode that neither table recognises sends the sequencer back to fetch and raises an invalid-opcode flag for that cycle.

Top module: `ucode_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `upc` is 0, `ctrl` is 16'h9408 and `bad_op` is 0.
- R2: The bits of `ctrl`, from bit 15 down to bit 0, are: PC write, conditional PC write, address-from-ALU-result select, memory read, memory write, instruction-register write, register data from memory, PC source [1:0] (bits 8:7), ALU operation [1:0] (bits 6:5), second ALU operand select [1:0] (bits 4:3), first ALU operand select, register write, destination from rd field.
- R3: From micro-address 0 the next micro-address is always 1. The fetch word's address-control value is 3, which means increment.
- R4: At micro-address 1 (address-control value 1) the next micro-address depends on the opcode: 6'h00 (register-register) goes to 6, 6'h02 (jump) to 9, 6'h04 (branch-equal) to 8, and 6'h23 (load) or 6'h2B (store) to 2.
- R5: At micro-address 2 (address-control value 2) the next micro-address is 3 for opcode 6'h23 and 5 for opcode 6'h2B.
- R6: Micro-addresses 4, 5, 7, 8 and 9 carry address-control value 0 and are followed by micro-address 0.
- R7: Micro-address 6 is followed by micro-address 7, through the increment path.
- R8: When the current word dispatches and its table holds no entry for the opcode, `bad_op` is 1 in that cycle and the next micro-address is 0. In every other cycle `bad_op` is 0.
- R9: `ctrl` is 9408, 0018, 0014, 3000, 0202, 2800, 0044, 0003, 40A4 and 8100 (hex) at micro-addresses 0 to 9 in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 6 | Opcode field of the instruction register |
| ctrl | output | 16 | Datapath control vector of the current word |
| upc | output | 4 | Current micro-program counter |
| bad_op | output | 1 | Dispatch found no entry for the opcode |

## Verification
`ctrl` is decoded combinationally from the micro-program counter. Any wrong micro-address therefore shows up on `ctrl` and `upc` in the same cycle it is entered, and the bench compares both against its own model on every clock. A wrong dispatch entry appears exactly one cycle after the decode or memory-address word. A wrong address-control field appears one cycle after the word that carries it. A load whose opcode is swapped for an unknown one after decode exercises the second table's miss path. That path is the only way to reach `bad_op` at micro-address 2.

// File: rtl/ucode_seq.sv
module ucode_seq #(
  parameter int OPW = 6,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  output logic [15:0]    ctrl,
  output logic [AW-1:0]  upc,
  output logic           bad_op
);
  localparam int CW = 16;
  localparam int WW = CW + 2;

  localparam logic [OPW-1:0] OP_RR  = OPW'(6'h00);
  localparam logic [OPW-1:0] OP_JMP = OPW'(6'h02);
  localparam logic [OPW-1:0] OP_BEQ = OPW'(6'h04);
  localparam logic [OPW-1:0] OP_LD  = OPW'(6'h23);
  localparam logic [OPW-1:0] OP_ST  = OPW'(6'h2B);

  localparam logic [1:0] AC_ZERO = 2'd0;
  localparam logic [1:0] AC_TBL1 = 2'd1;
  localparam logic [1:0] AC_TBL2 = 2'd2;
  localparam logic [1:0] AC_INCR = 2'd3;

  function automatic logic [WW-1:0] store_word(input logic [AW-1:0] a);
    case (a)
      AW'(0):  store_word = {16'h9408, AC_INCR};
      AW'(1):  store_word = {16'h0018, AC_TBL1};
      AW'(2):  store_word = {16'h0014, AC_TBL2};
      AW'(3):  store_word = {16'h3000, AC_INCR};
      AW'(4):  store_word = {16'h0202, AC_ZERO};
      AW'(5):  store_word = {16'h2800, AC_ZERO};
      AW'(6):  store_word = {16'h0044, AC_INCR};
      AW'(7):  store_word = {16'h0003, AC_ZERO};
      AW'(8):  store_word = {16'h40A4, AC_ZERO};
      AW'(9):  store_word = {16'h8100, AC_ZERO};
      default: store_word = {16'h0000, AC_ZERO};
    endcase
  endfunction

  function automatic logic [AW:0] table1(input logic [OPW-1:0] op);
    case (op)
      OP_RR:        table1 = {1'b1, AW'(6)};
      OP_JMP:       table1 = {1'b1, AW'(9)};
      OP_BEQ:       table1 = {1'b1, AW'(8)};
      OP_LD, OP_ST: table1 = {1'b1, AW'(2)};
      default:      table1 = {1'b0, AW'(0)};
    endcase
  endfunction

  function automatic logic [AW:0] table2(input logic [OPW-1:0] op);
    case (op)
      OP_LD:   table2 = {1'b1, AW'(3)};
      OP_ST:   table2 = {1'b1, AW'(5)};
      default: table2 = {1'b0, AW'(0)};
    endcase
  endfunction

  logic [WW-1:0] word;
  logic [1:0]    actl;
  logic [AW:0]   hit1, hit2;
  logic [AW-1:0] nxt;

  assign word = store_word(upc);
  assign ctrl = word[WW-1:2];
  assign actl = word[1:0];
  assign hit1 = table1(opcode);
  assign hit2 = table2(opcode);
  assign bad_op = (actl == AC_TBL1 && !hit1[AW]) || (actl == AC_TBL2 && !hit2[AW]);

  always_comb begin
    case (actl)
      AC_TBL1: nxt = hit1[AW-1:0];
      AC_TBL2: nxt = hit2[AW-1:0];
      AC_INCR: nxt = upc + AW'(1);
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upc <= '0;
    else        upc <= nxt;
  end

  // R3
  fetch_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upc == AW'(0) |=> upc == AW'(1));

  // R4
  decode_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == AW'(1) && !bad_op) |=> upc inside {AW'(2), AW'(6), AW'(8), AW'(9)});

  // R5
  mem_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == AW'(2) && !bad_op) |=> upc inside {AW'(3), AW'(5)});

  // R6
  routine_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upc inside {AW'(4), AW'(5), AW'(7), AW'(8), AW'(9)} |=> upc == AW'(0));

  // R7
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upc == AW'(6) |=> upc == AW'(7));

  // R8
  bad_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |=> upc == AW'(0));

  // R8
  bad_where_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> upc inside {AW'(1), AW'(2)});

  // R2
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl[12] && ctrl[11]));
endmodule

// File: tb/ucode_seq_bench.sv
module ucode_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = 6'h00;
  logic [15:0] ctrl;
  logic [3:0]  upc;
  logic        bad_op;

  ucode_seq u_ucode_seq (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .ctrl(ctrl), .upc(upc), .bad_op(bad_op)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad_n = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] want_ctrl(input int a);
    case (a)
      0: want_ctrl = 16'h9408;
      1: want_ctrl = 16'h0018;
      2: want_ctrl = 16'h0014;
      3: want_ctrl = 16'h3000;
      4: want_ctrl = 16'h0202;
      5: want_ctrl = 16'h2800;
      6: want_ctrl = 16'h0044;
      7: want_ctrl = 16'h0003;
      8: want_ctrl = 16'h40A4;
      9: want_ctrl = 16'h8100;
      default: want_ctrl = 16'h0000;
    endcase
  endfunction

  int op_q[$];
  int late_q[$];

  initial begin
    int cur_late;
    int e_upc;
    int e_nxt;
    bit e_bad;
    string tag;
    op_q   = '{'h00, 'h23, 'h2B, 'h04, 'h02, 'h3F, 'h23, 'h00, 'h11, 'h2B, 'h23, 'h04, 'h02, 'h00};
    late_q = '{-1,   -1,   -1,   -1,   -1,   -1,   'h3F, -1,   -1,   -1,   'h04, -1,   -1,   -1};
    cur_late = -1;
    opcode = 6'h23;
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset upc", 32'(upc), 32'd0);
      chk("R1 reset ctrl", 32'(ctrl), 32'h9408);
      chk("R1 reset bad_op", 32'(bad_op), 32'd0);
    end
    rst_n = 1'b1;
    e_upc = 0;
    tag = "R1";
    forever begin
      if (e_upc == 0) begin
        if (op_q.size() == 0) break;
        opcode = 6'(op_q.pop_front());
        cur_late = late_q.pop_front();
      end
      if (e_upc == 2 && cur_late >= 0) opcode = 6'(cur_late);
      #1;
      e_bad = 1'b0;
      case (e_upc)
        0: e_nxt = 1;
        1: case (int'(opcode))
             'h00: e_nxt = 6;
             'h02: e_nxt = 9;
             'h04: e_nxt = 8;
             'h23, 'h2B: e_nxt = 2;
             default: begin e_nxt = 0; e_bad = 1'b1; end
           endcase
        2: case (int'(opcode))
             'h23: e_nxt = 3;
             'h2B: e_nxt = 5;
             default: begin e_nxt = 0; e_bad = 1'b1; end
           endcase
        3: e_nxt = 4;
        6: e_nxt = 7;
        default: e_nxt = 0;
      endcase
      chk({tag, " upc"}, 32'(upc), 32'(e_upc));
      chk("R9 ctrl word", 32'(ctrl), 32'(want_ctrl(e_upc)));
      chk("R8 bad_op", 32'(bad_op), 32'(e_bad));
      if (e_upc == 4) chk("R2 load writeback fields", 32'({ctrl[9], ctrl[1], ctrl[0]}), 32'b110);
      if (e_upc == 8) chk("R2 branch fields", 32'({ctrl[14], ctrl[8:7], ctrl[6:5]}), 32'b10101);
      if (e_upc == 3) chk("R2 load read fields", 32'({ctrl[13], ctrl[12], ctrl[11]}), 32'b110);
      if (e_upc == 0) chk("R2 fetch fields", 32'({ctrl[15], ctrl[10], ctrl[4:3]}), 32'b1101);
      if (e_bad) tag = "R8";
      else case (e_upc)
        0: tag = "R3";
        1: tag = "R4";
        2: tag = "R5";
        6: tag = "R7";
        3: tag = "R9 increment";
        default: tag = "R6";
      endcase
      @(posedge clk);
      e_upc = e_nxt;
      @(negedge clk);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad_n);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad_n++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad_n);
      $finish;
    end
  end
endmodule